// File: doc/BRIEF.md
# DQS Read-Capture Tap Sweep Calibrator

This block finds a read-capture delay setting for two DQS byte lanes without software help. When started, it sweeps a single delay tap shared by both lanes upward from zero through the top of its range. Before each tap it issues a lane-tap write. It then starts an external memory self-test and waits for the test to finish. The returned comparison count decides whether that tap passes. The block remembers the earliest passing tap and the most recent one, and at the end it programs both lanes with the midpoint of that span.

The pass span always runs from the earliest pass to the latest pass, even if failing taps lie between them. If no tap passes, the lane setting that was in place when the sweep began is written back. A programmable timeout on each self-test wait marks a test that never answers as a fail, so the sweep always finishes. One write strobe carries every tap value, because both lanes always receive the same value.

Top module: `dqs_tap_cal`

## Requirements
- R1: After synchronous reset, `cal_busy`, `cal_done`, `tap_wr` and `bist_go` are 0, and `tap_out` and `result_tap` are 0.
- R2: A start accepted while idle produces lane-tap writes of 0, 1, ..., 2^TAP_W-1 in increasing order, one single-cycle `tap_wr` pulse each. `bist_go` rises in the cycle directly after each of these writes.
- R3: `bist_go` stays high until `bist_done` is sampled high, or until the timeout expires, and falls in the following cycle. `bist_go` is never high during a `tap_wr` cycle, and exactly one test is run per tap.
- R4: A tap passes only when `bist_done` arrives with `bist_count` exactly equal to EXPECT_CNT (default 8). Any other value, including one that differs only in upper bits, is a fail.
- R5: When at least one tap passes, the final written tap is (first + last) / 2, rounded down and reduced modulo 2^TAP_W. Here first is the earliest passing tap and last is the latest passing tap, whether or not failing taps lie between them.
- R6: When no tap passes, the final written tap equals the `lane0_tap` value sampled in the cycle the start was accepted.
- R7: If `bist_done` has not appeared after TIMEOUT_CYC cycles of `bist_go`, the block drops `bist_go` and counts that tap as a fail. `bist_go` is never high for more than TIMEOUT_CYC consecutive cycles.
- R8: `cal_busy` is high from the cycle after the start through the cycle of the final tap write. `cal_done` is a one-cycle pulse in the cycle where `cal_busy` falls. `result_tap` carries the final tap and holds it while the block is idle. The total is 2^TAP_W + 1 writes per calibration.
- R9: `cal_start` is ignored while `cal_busy` is high. It causes no extra writes, no restart and no second done pulse.
- R10: Tap 0 counts as a genuine first pass. If tap 0 is the only pass, the result is 0, not the restored setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_start | input | 1 | Start request, taken only while idle |
| lane0_tap | input | TAP_W | Current lane 0 tap setting, sampled at start |
| cal_busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | One-cycle completion pulse |
| tap_out | output | TAP_W | Tap value for both lanes |
| tap_wr | output | 1 | Write strobe for `tap_out` into both lanes |
| result_tap | output | TAP_W | Tap chosen by the last calibration |
| bist_go | output | 1 | Self-test start level |
| bist_done | input | 1 | Self-test finished flag |
| bist_count | input | CNT_W | Comparison count returned by the self-test |

## Verification
The sweep is run against pass maps that each separate one behaviour from its likely mistakes:
- A contiguous run plus an isolated later pass separates the first-to-latest span from a longest-run choice.
- Passes at both ends of the range, and a pass only at tap 0, show that tap 0 is recorded as a real first pass.
- A map with no passes shows the saved setting being restored.

Counts near the expected value (one too many, and a correct low nibble with extra upper bits) test that the compare is exact. Taps whose self-test never answers test the timeout path and its exact length. A start pulse in the middle of a sweep must leave the write sequence and the single done pulse unchanged.

// File: rtl/dqs_cal_pkg.sv
package dqs_cal_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SET,
    S_WAIT,
    S_FINAL,
    S_DONE
  } cal_state_t;

endpackage

// File: rtl/dqs_cal_probe.sv
// Runs one self-test per request: raises go, waits for done or a timeout,
// then reports a one-cycle verdict.
module dqs_cal_probe #(
  parameter int CNT_W       = 8,
  parameter int EXPECT_CNT  = 8,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             bist_done,
  input  logic [CNT_W-1:0] bist_count,
  output logic             bist_go,
  output logic             res_valid,
  output logic             res_pass
);

  localparam int TMR_W = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;

  logic go_q;
  logic vld_q;
  logic pass_q;
  logic expired;

  generate
    if (TIMEOUT_CYC > 0) begin : g_tmo
      logic [TMR_W-1:0] tmr_q;
      always_ff @(posedge clk) begin
        if (rst || !go_q) tmr_q <= '0;
        else              tmr_q <= tmr_q + 1'b1;
      end
      assign expired = go_q && (tmr_q == TMR_W'(TIMEOUT_CYC - 1));
    end else begin : g_no_tmo
      assign expired = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      go_q   <= 1'b0;
      vld_q  <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (launch) begin
        go_q <= 1'b1;
      end else if (go_q && bist_done) begin
        go_q   <= 1'b0;
        vld_q  <= 1'b1;
        pass_q <= (bist_count == CNT_W'(EXPECT_CNT));
      end else if (expired) begin
        go_q   <= 1'b0;
        vld_q  <= 1'b1;
        pass_q <= 1'b0;
      end
    end
  end

  assign bist_go   = go_q;
  assign res_valid = vld_q;
  assign res_pass  = pass_q;

endmodule

// File: rtl/dqs_cal_window.sv
// Tracks earliest and latest passing taps and the number of passes.
module dqs_cal_window #(
  parameter int TAP_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             hit,
  input  logic [TAP_W-1:0] hit_tap,
  output logic             any_pass,
  output logic [TAP_W-1:0] mid_tap
);

  logic [TAP_W-1:0] first_q;
  logic [TAP_W-1:0] last_q;
  logic             seen_q;
  logic [TAP_W:0]   cnt_q;
  logic [TAP_W:0]   span_sum;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      first_q <= '0;
      last_q  <= '0;
      seen_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (hit) begin
      if (!seen_q) first_q <= hit_tap;
      last_q <= hit_tap;
      seen_q <= 1'b1;
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // Halving the (TAP_W+1)-bit sum keeps TAP_W bits, i.e. modulo the range.
  assign span_sum = {1'b0, first_q} + {1'b0, last_q};
  assign mid_tap  = span_sum[TAP_W:1];
  assign any_pass = (cnt_q != '0);

endmodule

// File: rtl/dqs_cal_seq.sv
// Sweep sequencer: owns the tap index, the lane writes and the handshake.
module dqs_cal_seq
  import dqs_cal_pkg::*;
#(
  parameter int TAP_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cal_start,
  input  logic [TAP_W-1:0] lane0_tap,
  input  logic             res_valid,
  input  logic             any_pass,
  input  logic [TAP_W-1:0] mid_tap,
  output logic             launch,
  output logic             clear,
  output logic [TAP_W-1:0] sweep_tap,
  output logic [TAP_W-1:0] tap_out,
  output logic             tap_wr,
  output logic             cal_busy,
  output logic             cal_done,
  output logic [TAP_W-1:0] result_tap
);

  localparam logic [TAP_W-1:0] TOP_TAP = {TAP_W{1'b1}};

  cal_state_t       state_q;
  logic [TAP_W-1:0] idx_q;
  logic [TAP_W-1:0] saved_q;
  logic [TAP_W-1:0] out_q;
  logic [TAP_W-1:0] res_q;
  logic             wr_q;
  logic             busy_q;
  logic             done_q;
  logic [TAP_W-1:0] final_tap;

  assign final_tap = any_pass ? mid_tap : saved_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      saved_q <= '0;
      out_q   <= '0;
      res_q   <= '0;
      wr_q    <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      wr_q   <= 1'b0;
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (cal_start) begin
            saved_q <= lane0_tap;
            idx_q   <= '0;
            out_q   <= '0;
            wr_q    <= 1'b1;
            busy_q  <= 1'b1;
            state_q <= S_SET;
          end
        end
        S_SET: begin
          state_q <= S_WAIT;
        end
        S_WAIT: begin
          if (res_valid) begin
            if (idx_q == TOP_TAP) begin
              state_q <= S_FINAL;
            end else begin
              idx_q   <= idx_q + 1'b1;
              out_q   <= idx_q + 1'b1;
              wr_q    <= 1'b1;
              state_q <= S_SET;
            end
          end
        end
        S_FINAL: begin
          out_q   <= final_tap;
          res_q   <= final_tap;
          wr_q    <= 1'b1;
          state_q <= S_DONE;
        end
        S_DONE: begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign launch     = (state_q == S_SET);
  assign clear      = (state_q == S_IDLE) && cal_start;
  assign sweep_tap  = idx_q;
  assign tap_out    = out_q;
  assign tap_wr     = wr_q;
  assign cal_busy   = busy_q;
  assign cal_done   = done_q;
  assign result_tap = res_q;

endmodule

// File: rtl/dqs_tap_cal.sv
module dqs_tap_cal #(
  parameter int TAP_W       = 6,
  parameter int CNT_W       = 8,
  parameter int EXPECT_CNT  = 8,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cal_start,
  input  logic [TAP_W-1:0] lane0_tap,
  output logic             cal_busy,
  output logic             cal_done,
  output logic [TAP_W-1:0] tap_out,
  output logic             tap_wr,
  output logic [TAP_W-1:0] result_tap,
  output logic             bist_go,
  input  logic             bist_done,
  input  logic [CNT_W-1:0] bist_count
);

  logic             launch;
  logic             clear;
  logic             res_valid;
  logic             res_pass;
  logic             any_pass;
  logic [TAP_W-1:0] mid_tap;
  logic [TAP_W-1:0] sweep_tap;

  dqs_cal_seq #(.TAP_W(TAP_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .cal_start  (cal_start),
    .lane0_tap  (lane0_tap),
    .res_valid  (res_valid),
    .any_pass   (any_pass),
    .mid_tap    (mid_tap),
    .launch     (launch),
    .clear      (clear),
    .sweep_tap  (sweep_tap),
    .tap_out    (tap_out),
    .tap_wr     (tap_wr),
    .cal_busy   (cal_busy),
    .cal_done   (cal_done),
    .result_tap (result_tap)
  );

  dqs_cal_probe #(
    .CNT_W       (CNT_W),
    .EXPECT_CNT  (EXPECT_CNT),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_probe (
    .clk        (clk),
    .rst        (rst),
    .launch     (launch),
    .bist_done  (bist_done),
    .bist_count (bist_count),
    .bist_go    (bist_go),
    .res_valid  (res_valid),
    .res_pass   (res_pass)
  );

  dqs_cal_window #(.TAP_W(TAP_W)) u_window (
    .clk      (clk),
    .rst      (rst),
    .clear    (clear),
    .hit      (res_valid && res_pass),
    .hit_tap  (sweep_tap),
    .any_pass (any_pass),
    .mid_tap  (mid_tap)
  );

endmodule

// File: rtl/dqs_tap_cal_chk.sv
module dqs_tap_cal_chk #(
  parameter int TAP_W       = 6,
  parameter int TIMEOUT_CYC = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             cal_busy,
  input logic             cal_done,
  input logic             tap_wr,
  input logic [TAP_W-1:0] result_tap,
  input logic             bist_go,
  input logic             bist_done
);

  int unsigned go_cnt;

  always_ff @(posedge clk) begin
    if (rst || !bist_go) go_cnt <= 0;
    else                 go_cnt <= go_cnt + 1;
  end

  p_go_after_write_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(bist_go) |-> $past(tap_wr));

  p_no_go_on_write_r3: assert property (@(posedge clk) disable iff (rst)
    tap_wr |-> !bist_go);

  p_go_drops_r3: assert property (@(posedge clk) disable iff (rst)
    (bist_go && bist_done) |=> !bist_go);

  p_go_bounded_r7: assert property (@(posedge clk) disable iff (rst)
    bist_go |-> (go_cnt < TIMEOUT_CYC));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    cal_done |=> !cal_done);

  p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (rst)
    cal_done |-> (!cal_busy && $past(cal_busy)));

  p_result_moves_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (result_tap != $past(result_tap)) |-> cal_busy);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !cal_busy |-> (!tap_wr && !bist_go));

endmodule

bind dqs_tap_cal dqs_tap_cal_chk #(
  .TAP_W       (TAP_W),
  .TIMEOUT_CYC (TIMEOUT_CYC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cal_busy   (cal_busy),
  .cal_done   (cal_done),
  .tap_wr     (tap_wr),
  .result_tap (result_tap),
  .bist_go    (bist_go),
  .bist_done  (bist_done)
);

// File: tb/dqs_tap_cal_bench.sv
`timescale 1ns/1ps
module dqs_tap_cal_bench;

  localparam int TAP_W = 6;
  localparam int NTAP  = 1 << TAP_W;
  localparam int TMO   = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cal_start = 1'b0;
  logic [TAP_W-1:0] lane0_tap = '0;
  logic             cal_busy, cal_done, tap_wr, bist_go;
  logic [TAP_W-1:0] tap_out, result_tap;
  logic             bist_done = 1'b0;
  logic [7:0]       bist_count = '0;

  always #4 clk = ~clk;

  dqs_tap_cal #(.TAP_W(TAP_W), .CNT_W(8), .EXPECT_CNT(8), .TIMEOUT_CYC(TMO))
  u_dqs_tap_cal (
    .clk(clk), .rst(rst), .cal_start(cal_start), .lane0_tap(lane0_tap),
    .cal_busy(cal_busy), .cal_done(cal_done), .tap_out(tap_out),
    .tap_wr(tap_wr), .result_tap(result_tap), .bist_go(bist_go),
    .bist_done(bist_done), .bist_count(bist_count)
  );

  int nchk = 0;
  int nfail = 0;

  // Self-test model configuration
  logic [7:0] cnt_map [NTAP];
  logic [NTAP-1:0] hang_map;
  int lat = 2;

  // Monitor state
  int model_tap = 0;
  int go_run = 0;
  int go_run_max = 0;
  int go_rises = 0;
  int overlap = 0;
  int done_n = 0;
  int wr_n = 0;
  int wr_log [NTAP+8];
  logic go_prev = 1'b0;

  always @(negedge clk) begin
    if (tap_wr) begin
      model_tap = int'(tap_out);
      if (wr_n < NTAP + 8) wr_log[wr_n] = int'(tap_out);
      wr_n++;
    end
    if (tap_wr && bist_go) overlap++;
    if (cal_done) done_n++;
    if (bist_go && !go_prev) go_rises++;
    go_prev = bist_go;
    if (bist_go) begin
      go_run++;
      if (go_run > go_run_max) go_run_max = go_run;
      if (!hang_map[model_tap] && go_run >= lat) begin
        bist_done  = 1'b1;
        bist_count = cnt_map[model_tap];
      end
    end else begin
      go_run    = 0;
      bist_done = 1'b0;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      nfail++;
      $display("FAIL watchdog: run did not finish act=%0d exp<190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic set_all(input logic [7:0] v);
    for (int t = 0; t < NTAP; t++) cnt_map[t] = v;
    hang_map = '0;
  endtask

  function automatic int exp_tap(input int seed);
    int first = -1;
    int last = 0;
    int n = 0;
    for (int t = 0; t < NTAP; t++) begin
      if (!hang_map[t] && cnt_map[t] == 8'd8) begin
        if (first < 0) first = t;
        last = t;
        n++;
      end
    end
    return (n > 0) ? (((first + last) / 2) % NTAP) : seed;
  endfunction

  // Runs one calibration; poke>=0 pulses cal_start that many cycles in.
  task automatic run_sweep(input string req, input int seed, input int poke);
    int exp = exp_tap(seed);
    int bad = 0;
    bit seen = 0;
    wr_n = 0; go_rises = 0; overlap = 0; done_n = 0; go_run_max = 0;
    @(negedge clk);
    lane0_tap = TAP_W'(seed);
    cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
    lane0_tap = TAP_W'(seed ^ 21);
    chk({req, " R8 busy after start"}, int'(cal_busy), 1);
    for (int i = 0; i < 20000; i++) begin
      if (i == poke) cal_start = 1'b1;
      else           cal_start = 1'b0;
      if (cal_done) begin
        seen = 1;
        break;
      end
      @(negedge clk);
    end
    cal_start = 1'b0;
    chk({req, " R8 done seen"}, int'(seen), 1);
    chk({req, " R8 busy low with done"}, int'(cal_busy), 0);
    @(negedge clk);
    chk({req, " R8 done one cycle"}, int'(cal_done), 0);
    for (int i = 0; i < 12; i++) @(negedge clk);
    chk({req, " R8 write count"}, wr_n, NTAP + 1);
    for (int t = 0; t < NTAP; t++) if (wr_log[t] != t) bad++;
    chk({req, " R2 write order"}, bad, 0);
    chk({req, " R3 one test per tap"}, go_rises, NTAP);
    chk({req, " R3 no go during write"}, overlap, 0);
    chk({req, " R5 final write"}, wr_log[NTAP], exp);
    chk({req, " R8 result_tap"}, int'(result_tap), exp);
    chk({req, " R9 single done"}, done_n, 1);
  endtask

  task automatic t_reset;
    chk("R1 busy", int'(cal_busy), 0);
    chk("R1 done", int'(cal_done), 0);
    chk("R1 tap_wr", int'(tap_wr), 0);
    chk("R1 bist_go", int'(bist_go), 0);
    chk("R1 tap_out", int'(tap_out), 0);
    chk("R1 result_tap", int'(result_tap), 0);
  endtask

  task automatic t_gap_window;
    set_all(8'd7);
    for (int t = 10; t <= 20; t++) cnt_map[t] = 8'd8;
    cnt_map[40] = 8'd8;
    lat = 2;
    run_sweep("R5 gap", 5, -1);
    chk("R5 gap midpoint 25", int'(result_tap), 25);
  endtask

  task automatic t_no_pass;
    set_all(8'd0);
    lat = 4;
    run_sweep("R6 none", 37, -1);
    chk("R6 restored 37", int'(result_tap), 37);
  endtask

  task automatic t_tap_zero;
    set_all(8'd3);
    cnt_map[0] = 8'd8;
    cnt_map[63] = 8'd8;
    lat = 1;
    run_sweep("R10 ends", 9, -1);
    chk("R10 ends midpoint 31", int'(result_tap), 31);
    set_all(8'd3);
    cnt_map[0] = 8'd8;
    run_sweep("R10 only0", 50, -1);
    chk("R10 only tap0 gives 0", int'(result_tap), 0);
  endtask

  task automatic t_exact_count;
    set_all(8'd0);
    for (int t = 5; t <= 9; t++) cnt_map[t] = 8'd8;
    cnt_map[30] = 8'd9;
    cnt_map[50] = 8'h88;
    cnt_map[61] = 8'h10;
    lat = 3;
    run_sweep("R4 exact", 44, -1);
    chk("R4 near counts fail -> 7", int'(result_tap), 7);
  endtask

  task automatic t_timeout;
    set_all(8'd8);
    hang_map = '1;
    hang_map[12] = 1'b0;
    hang_map[13] = 1'b0;
    lat = 3;
    run_sweep("R7 hang", 2, -1);
    chk("R7 hung taps fail -> 12", int'(result_tap), 12);
    chk("R7 go length at timeout", go_run_max, TMO);
  endtask

  task automatic t_start_busy;
    set_all(8'd1);
    for (int t = 33; t <= 35; t++) cnt_map[t] = 8'd8;
    lat = 1;
    run_sweep("R9 poke", 0, 100);
    chk("R9 result unaffected 34", int'(result_tap), 34);
    chk("R9 idle no extra write", wr_n, NTAP + 1);
  endtask

  initial begin
    set_all(8'd0);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_gap_window();
    t_no_pass();
    t_tap_zero();
    t_exact_count();
    t_timeout();
    t_start_busy();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule